// File: doc/BRIEF.md
# Two-Clock Byte Memory with Clears and Unknown Tracking

This block is a 32-entry, byte-wide memory with one write port and one read port. Each port has its own clock. A write is captured on the rising edge of the write clock and is committed to the array on the falling edge that follows. A read is captured on the rising edge of the read clock when the read enable is high, and the byte appears on a registered output after that edge.

Clear inputs act on the write-side input registers, on the read address path and on the output register. A clear on a write-side register while a write is pending corrupts the stored contents. A clear on the write address loses every word. A clear on the write data or the write enable loses only the addressed word. The block runs on two-state logic, so it does not rely on X values to show a lost or unreliable byte. Each word carries a known flag, and the output carries an unknown flag. Whenever a result is unknown, `rd_unk` reads 1 and `rd_data` reads 8'h00.

While reset is active, the array is preloaded so that word n holds (8'hF0 + n) modulo 256. This gives simulation a defined starting image.

Top module: `sdp_clr_ram`

## Requirements
- R1: When `rd_en` is high at a rising edge of `rclk` and no unknown condition applies, `rd_data` shows the stored byte at `rd_addr` after that edge, and `rd_unk` is 0.
- R2: When `wr_en` is high at a rising edge of `wclk`, the byte on `wr_data` is committed to `wr_addr` on the next falling edge of `wclk`. A read captured at any later rising edge returns the new byte.
- R3: When `rd_en` is low at a rising edge of `rclk`, `rd_data` and `rd_unk` keep their values.
- R4: While `rq_clr` is high, `rd_data` is 8'h00 and `rd_unk` is 0. This takes effect at once, without waiting for a clock edge.
- R5: If `ra_clr` is high at a rising edge of `rclk` where `rd_en` is high, the result is unknown: `rd_unk` is 1 and `rd_data` is 8'h00.
- R6: When `wr_en` is low at a rising edge of `wclk`, the array is unchanged.
- R7: A read is unknown if, at the same rising edge, `wr_en` is high and `wr_addr` equals `rd_addr`.
- R8: If `wa_clr` is high at the falling edge of `wclk` that would commit a captured write, every word becomes unknown. The write is not performed. Reads of any word then give the unknown result.
- R9: If `wa_clr` is low and `wd_clr` or `we_clr` is high at that falling edge, only the addressed word becomes unknown. The write is not performed, and all other words keep their contents.
- R10: After reset, `rd_unk` is 1 and `rd_data` is 8'h00 until the first enabled read. Word n holds (8'hF0 + n) modulo 256.
- R11: A completed write to a word that was unknown makes that word known again with the new byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low reset. Sampled on the rising edges of both clocks and on the falling edge of `wclk` |
| wclk | input | 1 | Write clock |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write word address |
| wr_data | input | 8 | Write byte |
| wa_clr | input | 1 | Clear of the write address register |
| wd_clr | input | 1 | Clear of the write data register |
| we_clr | input | 1 | Clear of the write enable register |
| rclk | input | 1 | Read clock |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 5 | Read word address |
| ra_clr | input | 1 | Clear of the read address path |
| rq_clr | input | 1 | Asynchronous clear of the output register |
| rd_data | output | 8 | Registered read byte (8'h00 when unknown) |
| rd_unk | output | 1 | High when `rd_data` is not reliable |

## Verification
The read-side properties assume that `rq_clr` never pulses high and low again between two read edges. They also assume that the collision compare sees the write inputs stable around the read edge, which means the two clocks are aligned. The write-side properties assume that the clear inputs are steady at the falling edge of `wclk`. The stimulus meets all three assumptions. It drives both clocks from one source and changes every input 1 ns after a rising edge. It also holds `rq_clr` high across a full read edge before releasing it.

// File: rtl/sdp_pkg.sv
// Shared sizing for the two-clock byte memory. Assumes a power-of-two depth.
package sdp_pkg;
    localparam int SDP_DEPTH = 32;
    localparam int SDP_WIDTH = 8;
    localparam int SDP_AW    = $clog2(SDP_DEPTH);
    localparam logic [SDP_WIDTH-1:0] SDP_INIT_BASE = 8'hF0;
endpackage

// File: rtl/sdp_wr_regs.sv
// Write-side input registers. They capture enable, address and data on the
// rising write clock. Each clear zeroes its own register at that edge, with
// priority over the load. Assumes the inputs are stable around the edge.
module sdp_wr_regs #(
    parameter int AW = 5,
    parameter int W  = 8
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          wa_clr,
    input  logic          wd_clr,
    input  logic          we_clr,
    output logic          wen_q,
    output logic [AW-1:0] waddr_q,
    output logic [W-1:0]  wdata_q
);
    // Enable register: marks that a write cycle is open.
    always_ff @(posedge wclk) begin
        if (!rst_n || we_clr) wen_q <= 1'b0;
        else                  wen_q <= wr_en;
    end

    // Address register for the pending write.
    always_ff @(posedge wclk) begin
        if (!rst_n || wa_clr) waddr_q <= '0;
        else                  waddr_q <= wr_addr;
    end

    // Data register for the pending write.
    always_ff @(posedge wclk) begin
        if (!rst_n || wd_clr) wdata_q <= '0;
        else                  wdata_q <= wr_data;
    end
endmodule

// File: rtl/sdp_store.sv
// Storage array with one known flag per word. Commits the pending write on
// the falling write clock. A clear that is present at that commit edge
// invalidates either the addressed word or the whole array. Reset preloads
// word n with INIT_BASE + n. The read side is a combinational mux.
module sdp_store #(
    parameter int              DEPTH     = 32,
    parameter int              W         = 8,
    parameter int              AW        = 5,
    parameter logic [W-1:0]    INIT_BASE = 8'hF0
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wen_q,
    input  logic [AW-1:0] waddr_q,
    input  logic [W-1:0]  wdata_q,
    input  logic          wa_clr,
    input  logic          wd_clr,
    input  logic          we_clr,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_word,
    output logic          rd_ok
);
    logic [DEPTH-1:0][W-1:0] mem;
    logic [DEPTH-1:0]        valid;

    // Falling-edge commit, including the corruption cases.
    always_ff @(negedge wclk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i]   <= INIT_BASE + W'(i);
                valid[i] <= 1'b1;
            end
        end else if (wen_q) begin
            if (wa_clr) begin
                valid <= '0;
            end else if (wd_clr || we_clr) begin
                valid[waddr_q] <= 1'b0;
            end else begin
                mem[waddr_q]   <= wdata_q;
                valid[waddr_q] <= 1'b1;
            end
        end
    end

    // Read mux toward the output register.
    always_comb begin
        rd_word = mem[rd_addr];
        rd_ok   = valid[rd_addr];
    end

    a_r6_idle_keeps_array: assert property (@(negedge wclk) disable iff (!rst_n)
        !wen_q |=> ($stable(mem) && $stable(valid)));
    a_r2_commit_lands: assert property (@(negedge wclk) disable iff (!rst_n)
        (wen_q && !wa_clr && !wd_clr && !we_clr) |=>
        (mem[$past(waddr_q)] == $past(wdata_q)) && valid[$past(waddr_q)]);
    a_r8_addr_clear_loses_all: assert property (@(negedge wclk) disable iff (!rst_n)
        (wen_q && wa_clr) |=> (valid == '0));
    a_r9_word_clear_loses_one: assert property (@(negedge wclk) disable iff (!rst_n)
        (wen_q && !wa_clr && (wd_clr || we_clr)) |=> !valid[$past(waddr_q)]);
endmodule

// File: rtl/sdp_rd_reg.sv
// Read output register on the rising read clock. rq_clr zeroes it
// asynchronously. Otherwise an enabled read loads the addressed byte, or the
// unknown code (flag set, byte zero) on an address clear, a same-address
// write, or an unknown word. Assumes rq_clr spans at least one read edge.
module sdp_rd_reg #(
    parameter int W = 8
) (
    input  logic         rclk,
    input  logic         rst_n,
    input  logic         rd_en,
    input  logic         ra_clr,
    input  logic         rq_clr,
    input  logic         wr_hit,
    input  logic [W-1:0] word,
    input  logic         word_ok,
    output logic [W-1:0] rd_data,
    output logic         rd_unk
);
    logic bad_read;

    // Decide whether this read yields the unknown code.
    always_comb bad_read = ra_clr || wr_hit || !word_ok;

    // Output register with asynchronous clear.
    always_ff @(posedge rclk or posedge rq_clr) begin
        if (rq_clr) begin
            rd_data <= '0;
            rd_unk  <= 1'b0;
        end else if (!rst_n) begin
            rd_data <= '0;
            rd_unk  <= 1'b1;
        end else if (rd_en) begin
            rd_data <= bad_read ? '0 : word;
            rd_unk  <= bad_read;
        end
    end

    a_r3_disabled_read_holds: assert property (@(posedge rclk) disable iff (!rst_n)
        (!rd_en && !rq_clr) |=> (($stable(rd_data) && $stable(rd_unk)) || rq_clr));
    a_r4_clear_forces_zero: assert property (@(posedge rclk) disable iff (!rst_n)
        rq_clr |-> (rd_data == '0 && !rd_unk));
    a_r5_addr_clear_unknown: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_en && ra_clr && !rq_clr) |=> (rd_unk || rq_clr));
    a_r7_collision_unknown: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_en && wr_hit && !rq_clr) |=> (rd_unk || rq_clr));
endmodule

// File: rtl/sdp_clr_ram.sv
// Top level: two-clock byte memory with clears. It joins the write input
// registers, the storage array and the read output register. It also forms
// the same-cycle collision from the write inputs, which assumes the two
// clocks are aligned.
module sdp_clr_ram
    import sdp_pkg::*;
#(
    parameter int           DEPTH     = SDP_DEPTH,
    parameter int           W         = SDP_WIDTH,
    parameter logic [W-1:0] INIT_BASE = SDP_INIT_BASE,
    localparam int          AW        = $clog2(DEPTH)
) (
    input  logic          rst_n,
    input  logic          wclk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          wa_clr,
    input  logic          wd_clr,
    input  logic          we_clr,
    input  logic          rclk,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic          ra_clr,
    input  logic          rq_clr,
    output logic [W-1:0]  rd_data,
    output logic          rd_unk
);
    logic          wen_q;
    logic [AW-1:0] waddr_q;
    logic [W-1:0]  wdata_q;
    logic [W-1:0]  word;
    logic          word_ok;
    logic          wr_hit;

    // Same-edge write to the address being read.
    always_comb wr_hit = wr_en && (wr_addr == rd_addr);

    sdp_wr_regs #(.AW(AW), .W(W)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wa_clr(wa_clr), .wd_clr(wd_clr), .we_clr(we_clr),
        .wen_q(wen_q), .waddr_q(waddr_q), .wdata_q(wdata_q)
    );

    sdp_store #(.DEPTH(DEPTH), .W(W), .AW(AW), .INIT_BASE(INIT_BASE)) u_mem (
        .wclk(wclk), .rst_n(rst_n), .wen_q(wen_q), .waddr_q(waddr_q),
        .wdata_q(wdata_q), .wa_clr(wa_clr), .wd_clr(wd_clr), .we_clr(we_clr),
        .rd_addr(rd_addr), .rd_word(word), .rd_ok(word_ok)
    );

    sdp_rd_reg #(.W(W)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .rd_en(rd_en), .ra_clr(ra_clr),
        .rq_clr(rq_clr), .wr_hit(wr_hit), .word(word), .word_ok(word_ok),
        .rd_data(rd_data), .rd_unk(rd_unk)
    );
endmodule

// File: tb/sim_sdp_clr_ram.sv
module sim_sdp_clr_ram;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wa_clr = 1'b0, wd_clr = 1'b0, we_clr = 1'b0;
    logic [4:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0, ra_clr = 1'b0, rq_clr = 1'b0;
    logic [7:0] rd_data;
    logic       rd_unk;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2.5 clk = ~clk;

    sdp_clr_ram u0 (
        .rst_n(rst_n), .wclk(clk), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wa_clr(wa_clr), .wd_clr(wd_clr), .we_clr(we_clr),
        .rclk(clk), .rd_en(rd_en), .rd_addr(rd_addr), .ra_clr(ra_clr),
        .rq_clr(rq_clr), .rd_data(rd_data), .rd_unk(rd_unk)
    );

    // Fields: wen, waddr, wdata, ren, raddr, expected unk, expected data.
    localparam int NV = 15;
    localparam logic [28:0] VEC [NV] = '{
        {1'b0, 5'd0,  8'h00, 1'b1, 5'd0,  1'b0, 8'hF0},
        {1'b0, 5'd0,  8'h00, 1'b1, 5'd31, 1'b0, 8'h0F},
        {1'b1, 5'd5,  8'hA5, 1'b0, 5'd0,  1'b0, 8'h0F},
        {1'b0, 5'd0,  8'h00, 1'b1, 5'd5,  1'b0, 8'hA5},
        {1'b1, 5'd7,  8'h3C, 1'b1, 5'd7,  1'b1, 8'h00},
        {1'b0, 5'd0,  8'h00, 1'b1, 5'd7,  1'b0, 8'h3C},
        {1'b1, 5'd9,  8'h11, 1'b1, 5'd3,  1'b0, 8'hF3},
        {1'b0, 5'd0,  8'h00, 1'b0, 5'd9,  1'b0, 8'hF3},
        {1'b0, 5'd0,  8'h00, 1'b1, 5'd9,  1'b0, 8'h11},
        {1'b1, 5'd31, 8'hEE, 1'b1, 5'd30, 1'b0, 8'h0E},
        {1'b0, 5'd0,  8'h00, 1'b1, 5'd31, 1'b0, 8'hEE},
        {1'b1, 5'd0,  8'h5A, 1'b0, 5'd0,  1'b0, 8'hEE},
        {1'b0, 5'd0,  8'h00, 1'b1, 5'd0,  1'b0, 8'h5A},
        {1'b0, 5'd1,  8'h77, 1'b1, 5'd1,  1'b0, 8'hF1},
        {1'b0, 5'd0,  8'h00, 1'b1, 5'd1,  1'b0, 8'hF1}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic eu, input logic [7:0] ed);
        n_chk++;
        if (rd_unk !== eu || rd_data !== ed) begin
            n_bad++;
            $display("FAIL %s: actual unk=%0b data=%h, expected unk=%0b data=%h",
                     req, rd_unk, rd_data, eu, ed);
        end
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: actual run still going, expected finish before 100000 ns");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R10 reset state", 1'b1, 8'h00);

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            wr_en   = VEC[i][28];
            wr_addr = VEC[i][27:23];
            wr_data = VEC[i][22:15];
            rd_en   = VEC[i][14];
            rd_addr = VEC[i][13:9];
            tick();
            if (i < 2)               check("R10 preload", VEC[i][8], VEC[i][7:0]);
            else if (VEC[i][8])      check("R7 collision", VEC[i][8], VEC[i][7:0]);
            else if (!VEC[i][14])    check("R3 hold", VEC[i][8], VEC[i][7:0]);
            else if (i >= 13)        check("R6 suppressed write", VEC[i][8], VEC[i][7:0]);
            else                     check("R2 R1 read after write", VEC[i][8], VEC[i][7:0]);
        end
        wr_en = 1'b0; rd_en = 1'b0;

        // R4: asynchronous output clear, held across one read edge.
        rq_clr = 1'b1;
        #1;
        check("R4 async clear", 1'b0, 8'h00);
        tick();
        check("R4 clear held", 1'b0, 8'h00);
        rq_clr = 1'b0;

        // R5: read address clear at an enabled read.
        rd_en = 1'b1; rd_addr = 5'd2; ra_clr = 1'b1;
        tick();
        check("R5 addr clear", 1'b1, 8'h00);
        ra_clr = 1'b0;
        tick();
        check("R1 plain read", 1'b0, 8'hF2);

        // R8: address clear during a write cycle.
        rd_en = 1'b0; wr_en = 1'b1; wr_addr = 5'd4; wr_data = 8'h44;
        tick();
        wr_en = 1'b0; wa_clr = 1'b1;
        tick();
        wa_clr = 1'b0; rd_en = 1'b1; rd_addr = 5'd4;
        tick();
        check("R8 target word lost", 1'b1, 8'h00);
        rd_addr = 5'd20;
        tick();
        check("R8 other word lost", 1'b1, 8'h00);

        // R11: rewrite restores a word.
        rd_en = 1'b0; wr_en = 1'b1; wr_addr = 5'd20; wr_data = 8'h20;
        tick();
        wr_en = 1'b0; rd_en = 1'b1;
        tick();
        check("R11 rewrite known", 1'b0, 8'h20);

        // R9: data clear loses one word only.
        rd_en = 1'b0; wr_en = 1'b1; wr_addr = 5'd21; wr_data = 8'h21;
        tick();
        wr_addr = 5'd3; wr_data = 8'h33;
        tick();
        wr_en = 1'b0; wd_clr = 1'b1;
        tick();
        wd_clr = 1'b0; rd_en = 1'b1; rd_addr = 5'd3;
        tick();
        check("R9 data clear word", 1'b1, 8'h00);
        rd_addr = 5'd21;
        tick();
        check("R9 neighbour kept", 1'b0, 8'h21);

        // R9: enable clear loses one word only.
        rd_en = 1'b0; wr_en = 1'b1; wr_addr = 5'd21; wr_data = 8'h99;
        tick();
        wr_en = 1'b0; we_clr = 1'b1;
        tick();
        we_clr = 1'b0; rd_en = 1'b1; rd_addr = 5'd21;
        tick();
        check("R9 enable clear word", 1'b1, 8'h00);
        rd_addr = 5'd20;
        tick();
        check("R9 other kept", 1'b0, 8'h20);
        rd_en = 1'b0;
        tick();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule